// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block produces the coil-drive byte for a four-phase stepper motor. Each rising edge on the step input moves the motor by one position through a fixed table of byte codes. A direction input selects forward or reverse. A mode input selects full stepping, where two coils are on at every position, or half stepping, where single-coil codes sit between the two-coil codes. Every code repeats its low nibble in the high nibble, and the whole byte goes straight to the external coil drivers.

Internally a single 3-bit position indexes the eight-entry half-step table. The full-step codes sit at the odd positions. Full stepping moves the position by two, and half stepping moves it by one. When the block leaves half-step mode on an even position, it moves forward to the next odd position, so the output returns to a two-coil code. An enable input blanks the drive byte to zero and freezes motion.

Top module: `stepper_phase_seq`

## Requirements
- R1: After reset is released the output is 33H and the position is the first full-step entry.
- R2: With the mode input low (full stepping), accepted forward steps give the repeating output 33H, 66H, CCH, 99H, with 33H following 99H.
- R3: With the mode input high (half stepping), accepted forward steps give the repeating output 11H, 33H, 22H, 66H, 44H, CCH, 88H, 99H, with 11H following 99H.
- R4: A direction input of 1 moves forward through the active sequence and 0 moves backward. Both ends wrap around (33H goes back to 99H in full mode, and 11H goes back to 99H in half mode).
- R5: A step is accepted on a clock edge where the step input is sampled high after being sampled low on the previous edge. The new code appears after that same edge. A step input held high gives exactly one step.
- R6: On the first edge with the mode input low after half stepping on a single-coil code (11H, 22H, 44H or 88H), the output moves forward to the next two-coil code (33H, 66H, CCH or 99H respectively). If a step is accepted on that edge, it is applied from the aligned position.
- R7: Moving from full to half stepping keeps the current position and output code.
- R8: While enable is sampled low, the output is 00H and step edges are ignored. When enable returns high, the code shown is the one held before enable went low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | High to drive the coils; low blanks the output and freezes motion |
| step_in | input | 1 | Step request; each rising edge moves one position |
| dir_fwd | input | 1 | 1 = forward, 0 = backward |
| half_mode | input | 1 | 1 = half stepping, 0 = full stepping |
| phase_out | output | 8 | Coil drive byte |

## Verification
Forward runs through both tables, past the wrap point, confirm the order of each table. Backward runs across the first entry separate the two wrap directions. Mode toggles are made on both single-coil and two-coil positions, which shows whether alignment moves forward and whether the position is kept. A step input held high for several cycles, and step edges given while enable is low, show whether the block repeats steps or moves while blanked. A behavioural model compares the output on every clock throughout.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;
  localparam int POS_W  = 3;
  localparam int CODE_W = 8;
  localparam logic [POS_W-1:0] POS_HOME = 3'd1;

  // Coil code per half-step position; odd positions carry two-coil codes.
  function automatic logic [CODE_W-1:0] phase_code(input logic [POS_W-1:0] pos);
    logic [3:0] nib;
    case (pos)
      3'd0: nib = 4'h1;
      3'd1: nib = 4'h3;
      3'd2: nib = 4'h2;
      3'd3: nib = 4'h6;
      3'd4: nib = 4'h4;
      3'd5: nib = 4'hC;
      3'd6: nib = 4'h8;
      default: nib = 4'h9;
    endcase
    return {nib, nib};
  endfunction
endpackage

// File: rtl/stp_reset_sync.sv
module stp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/stp_step_detect.sv
module stp_step_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  output logic step_pulse
);
  logic step_q;
  logic step_d;

  always_comb begin
    step_d     = step_in;
    step_pulse = step_in & ~step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 1'b0;
    else        step_q <= step_d;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);  // R5
endmodule

// File: rtl/stp_phase_core.sv
module stp_phase_core
  import stepper_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pulse,
  input  logic              fwd,
  input  logic              half,
  output logic [CODE_W-1:0] code_o
);
  logic [POS_W-1:0]  pos_q, pos_d, base, delta;
  logic [CODE_W-1:0] code_q, code_d;
  logic              accept;

  always_comb begin
    accept = pulse & en;
    base   = half ? pos_q : (pos_q | 3'd1);
    if (fwd) delta = half ? 3'd1 : 3'd2;
    else     delta = half ? 3'd7 : 3'd6;
    pos_d  = accept ? (base + delta) : base;
    code_d = en ? phase_code(pos_d) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= POS_HOME;
      code_q <= phase_code(POS_HOME);
    end else begin
      pos_q  <= pos_d;
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

  AST_HALF_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (half && !pulse) |=> $stable(pos_q));  // R5
  AST_HALF_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (half && accept) |=> (pos_q != $past(pos_q)) && !(pos_q == $past(pos_q) + 3'd2)); // R4
  AST_FULL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !half) |=> (code_o == 8'h33 || code_o == 8'h66 || code_o == 8'hCC || code_o == 8'h99)); // R2
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (code_o == 8'h00));  // R8
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && half) |=> $stable(pos_q));  // R8
  AST_HALF_COILS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && half) |=> ($countones(code_o) == 2 || $countones(code_o) == 4)); // R3
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        step_in,
  input  logic        dir_fwd,
  input  logic        half_mode,
  output logic [7:0]  phase_out
);
  logic rst_int_n;
  logic pulse;
  logic [CODE_W-1:0] code;

  stp_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n));

  stp_step_detect u_edge (
    .clk(clk), .rst_n(rst_int_n), .step_in(step_in), .step_pulse(pulse));

  stp_phase_core u_core (
    .clk(clk), .rst_n(rst_int_n), .en(enable), .pulse(pulse),
    .fwd(dir_fwd), .half(half_mode), .code_o(code));

  assign phase_out = code;
endmodule

// File: tb/tb_stepper_phase_seq.sv
`timescale 1ns/1ps
module tb_stepper_phase_seq;
  logic clk = 1'b0;
  logic rst_n, enable, step_in, dir_fwd, half_mode;
  logic [7:0] phase_out;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  stepper_phase_seq dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_in(step_in),
    .dir_fwd(dir_fwd), .half_mode(half_mode), .phase_out(phase_out));

  always #4 clk = ~clk;

  // Behavioural reference model
  logic [7:0] tbl [8] = '{8'h11, 8'h33, 8'h22, 8'h66, 8'h44, 8'hCC, 8'h88, 8'h99};
  int m_pos, rcnt;
  bit m_prev, m_active;
  logic [7:0] m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 1; m_prev = 0; m_out = 8'h33; rcnt = 0; m_active = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      bit acc;
      int b;
      m_active = 1;
      acc = step_in && !m_prev && enable;
      m_prev = step_in;
      b = half_mode ? m_pos : (m_pos % 2 == 0 ? m_pos + 1 : m_pos);
      if (acc) b = b + (dir_fwd ? 1 : -1) * (half_mode ? 1 : 2);
      m_pos = (b + 8) % 8;
      m_out = enable ? tbl[m_pos] : 8'h00;
    end
  end

  task automatic check(input logic [7:0] exp, input string req);
    checks++;
    if (phase_out !== exp) begin
      fails++;
      $display("FAIL %s: phase_out=%h expected %h at %0t", req, phase_out, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check(m_out, cur_req);

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_step(input bit fwd);
    @(negedge clk); #1 dir_fwd = fwd; step_in = 1'b1;
    @(negedge clk); #1 step_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(input bit h);
    @(negedge clk); #1 half_mode = h;
    idle(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finish_run();
  end

  initial begin
    rst_n = 0; enable = 1; step_in = 0; dir_fwd = 1; half_mode = 0;
    idle(3);
    #1 rst_n = 1;
    idle(5);
    cur_req = "R1"; check(8'h33, "R1");

    cur_req = "R2";
    do_step(1); check(8'h66, "R2");
    do_step(1); check(8'hCC, "R2");
    do_step(1); check(8'h99, "R2");
    do_step(1); check(8'h33, "R2");

    cur_req = "R4";
    do_step(0); check(8'h99, "R4");
    do_step(0); check(8'hCC, "R4");
    do_step(1); check(8'h99, "R4");

    cur_req = "R7";
    set_mode(1); check(8'h99, "R7");

    cur_req = "R3";
    do_step(1); check(8'h11, "R3");
    do_step(1); check(8'h33, "R3");
    do_step(1); check(8'h22, "R3");
    do_step(1); check(8'h66, "R3");
    do_step(1); check(8'h44, "R3");

    cur_req = "R4";
    do_step(0); check(8'h66, "R4");
    do_step(0); check(8'h22, "R4");
    do_step(0); check(8'h33, "R4");
    do_step(0); check(8'h11, "R4");
    do_step(0); check(8'h99, "R4");
    do_step(1); check(8'h11, "R4");

    cur_req = "R6";
    set_mode(0); check(8'h33, "R6");
    set_mode(1); do_step(1); check(8'h22, "R6");
    set_mode(0); check(8'h66, "R6");
    set_mode(1); do_step(1); check(8'h44, "R6");
    // mode change and step on the same edge: align to CCH then step to 99H
    @(negedge clk); #1 half_mode = 0; dir_fwd = 1; step_in = 1;
    @(negedge clk); #1 step_in = 0;
    @(negedge clk); check(8'h99, "R6");

    cur_req = "R5";
    set_mode(1);
    @(negedge clk); #1 dir_fwd = 1; step_in = 1;
    idle(6); check(8'h11, "R5");
    #1 step_in = 0; idle(2); check(8'h11, "R5");

    cur_req = "R8";
    @(negedge clk); #1 enable = 0;
    idle(2); check(8'h00, "R8");
    do_step(1); check(8'h00, "R8");
    do_step(0); check(8'h00, "R8");
    @(negedge clk); #1 enable = 1;
    idle(2); check(8'h11, "R8");
    do_step(1); check(8'h33, "R8");

    cur_req = "R1";
    @(negedge clk); #1 rst_n = 0;
    idle(2); check(8'h33, "R1");
    #1 rst_n = 1; idle(4); check(8'h33, "R1");

    finish_run();
  end
endmodule